// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a 32-bit arithmetic unit for saturating operations. It performs signed and unsigned addition and subtraction that clamp at the limits of their number range. It also performs a signed addition that wraps but still reports overflow, and a width limiter that clamps a value to a programmable number of bits. The limiter works either on the full word or on two halfwords at once. Each operation is issued with a one-cycle valid strobe, and its result appears in a register one cycle later.

Any operation that clamps, and the overflow case of the wrapping add, sets a single sticky saturation flag. No arithmetic operation clears it. Only the dedicated clear input does, and a set in the same cycle wins over the clear. Software can run a sequence of operations and then test once whether any of them lost precision.

Top module: `satflag_alu`

## Requirements
- R1: During and right after reset (active-low, synchronous), `out_valid`, `result` and `sat_flag` are all 0.
- R2: A request with `in_valid` high is captured at the next rising edge, where `out_valid` goes high for exactly one cycle; while `in_valid` is low, `result` holds its value and `out_valid` is 0.
- R3: Opcode 0 (signed add): on overflow (same operand signs, sum sign differs from `opa`) the result is 0x7FFFFFFF when `opa` is non-negative and 0x80000000 when it is negative, and the flag is set; otherwise the result is the sum.
- R4: Opcode 1 (signed subtract `opa - opb`): on overflow (operand signs differ, difference sign differs from `opa`) the result clamps as in R3 and the flag is set.
- R5: Opcode 2 (unsigned add) gives 0xFFFFFFFF when the sum wraps; opcode 3 (unsigned subtract) gives 0 when `opb > opa`. Either clamp sets the flag.
- R6: Opcode 4 (wrapping signed add) always returns the modulo-2^32 sum and sets the flag on the signed overflow condition of R3.
- R7: Opcode 5 (signed word limit) clamps `opa` to [-2^n, 2^n-1], with n = `sat_amt`, and sets the flag when it clamps.
- R8: Opcode 6 (unsigned word limit) gives 0 for a negative `opa` and 2^n-1 for `opa` above 2^n-1, and sets the flag when it clamps.
- R9: Opcodes 8 (signed) and 9 (unsigned) apply the R7/R8 limits separately to sign-extended bits 15:0 and bits 31:16 of `opa`, pack the 16-bit results into the same positions, and set the flag if either half clamps.
- R10: The flag is sticky: an operation that does not clamp leaves it unchanged.
- R11: `flag_clr` clears the flag at the next edge, unless a request that sets the flag is captured at the same edge; then the flag is 1.
- R12: Opcodes 7 and 10 to 15 are reserved: they give result 0 and never set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand, input of the limit operations |
| opb | input | 32 | Second operand of add and subtract |
| sat_amt | input | 5 | Limit width n for opcodes 5, 6, 8, 9 |
| flag_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Setting the sticky flag and clearing it can land on the same clock edge. The bench provokes this by issuing a clamping signed add with `flag_clr` high, and requires the flag to read 1 afterwards. It then issues a non-clamping add with `flag_clr` high and requires the flag to read 0. These two cases show that the clear is honoured, but only when no set arrives in the same cycle.

// File: rtl/satflag_alu_pkg.sv
// Package: shared operation codes of the saturating arithmetic unit.
// Assumes a 4-bit opcode; unlisted codes are reserved.
package satflag_alu_pkg;
    typedef enum logic [3:0] {
        OP_SADD  = 4'd0,  // signed add, clamped
        OP_SSUB  = 4'd1,  // signed subtract, clamped
        OP_UADD  = 4'd2,  // unsigned add, clamped
        OP_USUB  = 4'd3,  // unsigned subtract, clamped
        OP_WADD  = 4'd4,  // signed add, wraps, flags overflow
        OP_SLIMW = 4'd5,  // signed width limit, word
        OP_ULIMW = 4'd6,  // unsigned width limit, word
        OP_SLIMH = 4'd8,  // signed width limit, two halfwords
        OP_ULIMH = 4'd9   // unsigned width limit, two halfwords
    } op_e;
endpackage

// File: rtl/satflag_addsub.sv
// Module: add/subtract datapath with signed and unsigned clamping.
// Purely combinational. Outputs the selected result and an overflow
// indication; ovf is 0 for opcodes this unit does not own.
module satflag_addsub
    import satflag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        op,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W:0]   sum_ext;
    logic [DATA_W-1:0] diff;
    logic              s_add_ovf, s_sub_ovf, u_carry, u_borrow;
    logic [DATA_W-1:0] s_clamp;

    // Raw sums and the four overflow conditions.
    always_comb begin
        sum_ext   = {1'b0, a} + {1'b0, b};
        diff      = a - b;
        s_add_ovf = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
        s_sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
        u_carry   = sum_ext[DATA_W];
        u_borrow  = (b > a);
        s_clamp   = a[MSB] ? NEG_MIN : POS_MAX;
    end

    // Result and overflow selection by opcode.
    always_comb begin
        res = sum_ext[MSB:0];
        ovf = 1'b0;
        unique case (op_e'(op))
            OP_SADD: begin res = s_add_ovf ? s_clamp : sum_ext[MSB:0]; ovf = s_add_ovf; end
            OP_SSUB: begin res = s_sub_ovf ? s_clamp : diff;           ovf = s_sub_ovf; end
            OP_UADD: begin res = u_carry ? '1 : sum_ext[MSB:0];        ovf = u_carry;   end
            OP_USUB: begin res = u_borrow ? '0 : diff;                 ovf = u_borrow;  end
            OP_WADD: begin res = sum_ext[MSB:0];                       ovf = s_add_ovf; end
            default: begin res = '0;                                    ovf = 1'b0;      end
        endcase
    end

    // Clamped signed results may only be one of the two range limits.
    always_comb begin
        if (ovf && (op_e'(op) == OP_SADD || op_e'(op) == OP_SSUB)) begin
            // R3
            sclamp_limit_chk: assert (res == POS_MAX || res == NEG_MIN);
        end
    end
endmodule

// File: rtl/satflag_limit.sv
// Module: width limiter. Clamps a W-bit two's-complement value to
// [-2^n, 2^n-1] (signed) or [0, 2^n-1] (unsigned), n = amt.
// Assumes IW exceeds 2^AMT_W so limits never overflow internally.
module satflag_limit #(
    parameter int W     = 32,
    parameter int AMT_W = 5,
    parameter int IW    = (1 << AMT_W) + 2
) (
    input  logic [W-1:0]     val,
    input  logic [AMT_W-1:0] amt,
    input  logic             is_signed,
    output logic [W-1:0]     res,
    output logic             clamped
);
    logic signed [IW-1:0] v_ext;
    logic signed [IW-1:0] lim_hi;
    logic signed [IW-1:0] lim_lo;

    // Sign-extend the input and build both limits for this width.
    always_comb begin
        v_ext  = {{(IW-W){val[W-1]}}, val};
        lim_hi = (IW'(1) << amt) - IW'(1);
        lim_lo = -(IW'(1) << amt);
    end

    // Compare against the limits and pick the clamped value.
    always_comb begin
        res     = val;
        clamped = 1'b0;
        if (is_signed) begin
            if (v_ext > lim_hi) begin
                res = lim_hi[W-1:0]; clamped = 1'b1;
            end else if (v_ext < lim_lo) begin
                res = lim_lo[W-1:0]; clamped = 1'b1;
            end
        end else begin
            if (v_ext[IW-1]) begin
                res = '0; clamped = 1'b1;
            end else if (v_ext > lim_hi) begin
                res = lim_hi[W-1:0]; clamped = 1'b1;
            end
        end
    end

    // Negative input in unsigned mode always clamps to zero.
    always_comb begin
        if (!is_signed && val[W-1]) begin
            // R8
            ulim_neg_chk: assert (clamped && res == '0);
        end
    end
endmodule

// File: rtl/satflag_sticky.sv
// Module: sticky saturation flag. Set by any clamping request,
// cleared only by clr; set wins over clear in the same cycle.
module satflag_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register: set has priority, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set && clr |=> flag);
    // R11
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set |=> !flag);
endmodule

// File: rtl/satflag_alu.sv
// Module: top of the saturating arithmetic unit. Decodes the opcode,
// routes operands to the add/subtract unit or the width limiters
// (one full word, NHALF halfwords), registers the result one cycle
// after in_valid and maintains the sticky flag.
module satflag_alu
    import satflag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [3:0]                op,
    input  logic [DATA_W-1:0]         opa,
    input  logic [DATA_W-1:0]         opb,
    input  logic [$clog2(DATA_W)-1:0] sat_amt,
    input  logic                      flag_clr,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         result,
    output logic                      sat_flag
);
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int NHALF  = 2;
    localparam int HALF_W = DATA_W / NHALF;

    logic [DATA_W-1:0] as_res, w_res, nxt_res;
    logic              as_ovf, w_cl, nxt_sat;
    logic [HALF_W-1:0] h_res [NHALF];
    logic              h_cl  [NHALF];
    logic              w_signed, h_signed;

    // Signedness of the limiters follows the opcode.
    always_comb begin
        w_signed = (op_e'(op) == OP_SLIMW);
        h_signed = (op_e'(op) == OP_SLIMH);
    end

    satflag_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a(opa), .b(opb), .op(op), .res(as_res), .ovf(as_ovf)
    );

    satflag_limit #(.W(DATA_W), .AMT_W(AMT_W)) u_lim_word (
        .val(opa), .amt(sat_amt), .is_signed(w_signed),
        .res(w_res), .clamped(w_cl)
    );

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        satflag_limit #(.W(HALF_W), .AMT_W(AMT_W)) u_lim_half (
            .val(opa[g*HALF_W +: HALF_W]), .amt(sat_amt), .is_signed(h_signed),
            .res(h_res[g]), .clamped(h_cl[g])
        );
    end

    // Select the result and saturation event of the requested operation.
    always_comb begin
        nxt_res = '0;
        nxt_sat = 1'b0;
        unique case (op_e'(op))
            OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_WADD: begin
                nxt_res = as_res; nxt_sat = as_ovf;
            end
            OP_SLIMW, OP_ULIMW: begin
                nxt_res = w_res; nxt_sat = w_cl;
            end
            OP_SLIMH, OP_ULIMH: begin
                for (int h = 0; h < NHALF; h++) begin
                    nxt_res[h*HALF_W +: HALF_W] = h_res[h];
                    nxt_sat = nxt_sat | h_cl[h];
                end
            end
            default: begin
                nxt_res = '0; nxt_sat = 1'b0;   // R12
            end
        endcase
    end

    // Result register: load on a request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= nxt_res;
        end
    end

    satflag_sticky u_flag (
        .clk(clk), .rst_n(rst_n), .set(in_valid && nxt_sat),
        .clr(flag_clr), .flag(sat_flag)
    );

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && !out_valid);
    // R10
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(in_valid));
    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == 4'd7 || op > 4'd9) |=> result == '0);
endmodule

// File: tb/satflag_alu_test.sv
`timescale 1ns/1ps
module satflag_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opa = '0, opb = '0;
    logic [4:0]  sat_amt = '0;
    logic        flag_clr = 1'b0;
    logic        out_valid, sat_flag;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    satflag_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa),
        .opb(opb), .sat_amt(sat_amt), .flag_clr(flag_clr),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    localparam int NV = 30;
    localparam logic [3:0] V_OP [NV] = '{
        4'd0, 4'd0, 4'd0, 4'd1, 4'd1, 4'd1, 4'd2, 4'd2, 4'd3, 4'd3,
        4'd4, 4'd4, 4'd5, 4'd5, 4'd5, 4'd5, 4'd5, 4'd5, 4'd6, 4'd6,
        4'd6, 4'd6, 4'd8, 4'd8, 4'd8, 4'd9, 4'd9, 4'd9, 4'd7, 4'd15};
    localparam logic [31:0] V_A [NV] = '{
        32'h7FFFFFFF, 32'h80000000, 32'h00000005, 32'h80000000, 32'h7FFFFFFF,
        32'h00000010, 32'hFFFFFFF0, 32'h00000001, 32'h00000005, 32'h00000006,
        32'h7FFFFFFF, 32'h00000003, 32'h00000100, 32'hFFFFFF00, 32'h0000007F,
        32'h80000000, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 32'h00001234,
        32'h000000FF, 32'h7FFFFFFF, 32'h0100FF00, 32'h00050FF0, 32'h80001234,
        32'hFFFF0300, 32'h00420010, 32'h00018000, 32'hFFFFFFFF, 32'h7FFFFFFF};
    localparam logic [31:0] V_B [NV] = '{
        32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFD, 32'h00000001, 32'hFFFFFFFF,
        32'h00000003, 32'h00000020, 32'h00000002, 32'h00000006, 32'h00000005,
        32'h00000001, 32'h00000004, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h00000001, 32'h00000001};
    localparam logic [4:0] V_N [NV] = '{
        5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0,
        5'd0, 5'd0, 5'd7, 5'd7, 5'd7, 5'd31, 5'd0, 5'd0, 5'd8, 5'd8,
        5'd8, 5'd31, 5'd7, 5'd12, 5'd15, 5'd8, 5'd8, 5'd16, 5'd3, 5'd3};
    localparam logic [31:0] V_RES [NV] = '{
        32'h7FFFFFFF, 32'h80000000, 32'h00000002, 32'h80000000, 32'h7FFFFFFF,
        32'h0000000D, 32'hFFFFFFFF, 32'h00000003, 32'h00000000, 32'h00000001,
        32'h80000000, 32'h00000007, 32'h0000007F, 32'hFFFFFF80, 32'h0000007F,
        32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h000000FF,
        32'h000000FF, 32'h7FFFFFFF, 32'h007FFF80, 32'h00050FF0, 32'h80001234,
        32'h000000FF, 32'h00420010, 32'h00010000, 32'h00000000, 32'h00000000};
    localparam logic V_SAT [NV] = '{
        1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
        1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
        1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2, 4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R8";
            4'd8, 4'd9: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; return after the next one.
    task automatic step(input logic v, input logic [3:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] n, input logic c);
        in_valid = v; op = o; opa = a; opb = b; sat_amt = n; flag_clr = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state, with a clamping request held during reset
        step(1'b1, 4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);
        step(1'b1, 4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        check("R1 sat_flag", {31'd0, sat_flag}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release out_valid", {31'd0, out_valid}, 32'd0);

        // Vector table: clear the flag, issue, then check result and flag.
        for (int i = 0; i < NV; i++) begin
            step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
            step(1'b1, V_OP[i], V_A[i], V_B[i], V_N[i], 1'b0);
            check({req_of(V_OP[i]), " result"}, result, V_RES[i]);
            check({req_of(V_OP[i]), " flag"}, {31'd0, sat_flag}, {31'd0, V_SAT[i]});
            check("R2 out_valid high", {31'd0, out_valid}, 32'd1);
        end

        // R2: no request -> result holds, out_valid low
        step(1'b0, 4'd2, 32'h00000010, 32'h00000020, 5'd0, 1'b0);
        check("R2 hold result", result, 32'h00000000);
        check("R2 out_valid low", {31'd0, out_valid}, 32'd0);

        // R10: flag survives a later non-clamping request
        step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
        step(1'b1, 4'd1, 32'h80000000, 32'h1, 5'd0, 1'b0);
        step(1'b1, 4'd2, 32'h1, 32'h2, 5'd0, 1'b0);
        check("R10 result", result, 32'h3);
        check("R10 sticky flag", {31'd0, sat_flag}, 32'd1);
        step(1'b0, 4'd5, 32'h7FFFFFFF, 32'h0, 5'd2, 1'b0);
        check("R10 idle keeps flag", {31'd0, sat_flag}, 32'd1);

        // R11: clear alone, set-and-clear together, clear with a non-clamping request
        step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
        check("R11 clear", {31'd0, sat_flag}, 32'd0);
        step(1'b1, 4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b1);
        check("R11 set beats clear", {31'd0, sat_flag}, 32'd1);
        check("R11 set result", result, 32'h7FFFFFFF);
        step(1'b1, 4'd0, 32'h1, 32'h1, 5'd0, 1'b1);
        check("R11 clear with quiet op", {31'd0, sat_flag}, 32'd0);

        // R12: reserved opcode 10 after a nonzero result gives zero, no flag
        step(1'b1, 4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0);
        check("R12 result", result, 32'h0);
        check("R12 flag", {31'd0, sat_flag}, 32'd0);

        step(1'b0, 4'd0, 32'h0, 32'h0, 5'd0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule